// File: doc/BRIEF.md
# Configurable Registered Command Buffer with Even-Parity Check

This block is a clocked register for a memory module's command and address path. Every rising clock edge it captures a word of inputs and drives it to registered outputs. A two-bit topology input picks one of two layouts. In the wide layout every input bit has one output. In the narrow layout only the low input bits are used, and each of them drives two output copies. In the narrow layout the topology input also says whether this device is the first or the second of a cascaded pair.

Beside the data, the block checks even parity: the checked data bits together with a parity bit from the controller must hold an even number of ones. The block registers a partial parity and drives it out, so that a first device can hand it to a second one. The second device merges that partial with its own data and raises the active-low error flag. Two active-low select inputs can freeze the data outputs. Parity checking keeps running while the outputs are frozen. A synchronous active-low reset clears everything.

Top module: `cfg_regbuf`

## Requirements
- R1: At every rising edge where `rst_n` is low, `q_a` and `q_b` go to all zeros, `casc_par_out` goes to 0 and `err_n` goes to 1.
- R2: Wide topology (`cfg[0]`=0, so codes 00 and 10): one edge after sampling, `q_a` equals `din` and `q_b` is all zeros.
- R3: Narrow topology (`cfg[0]`=1): one edge after sampling, `q_a[13:0]` and `q_b` both equal `din[13:0]` and `q_a[24:14]` is zero. `din[24:14]` affects neither the outputs nor the parity.
- R4: At an edge where both `sel_n` bits are high, the data bits of `q_a` and `q_b` keep their values. The control bits (positions set in `CTRL_MASK`, default bits 1 and 0) still load.
- R5: Parity results (`casc_par_out`, `err_n`) update the same way whether the outputs are frozen or not.
- R6: Wide topology: one edge after sampling, `casc_par_out` is the XOR of the checked bits and `par_in`. At the following edge `err_n` goes low exactly when that value was 1.
- R7: Bits set in `CTRL_MASK` never enter the parity computation.
- R8: Narrow first device (`cfg`=01): `casc_par_out` is the XOR of the checked low bits and `par_in`, and `err_n` stays high.
- R9: Narrow second device (`cfg`=11): `casc_par_out` is the XOR of the checked low bits, and `par_in` is ignored. At the next edge `err_n` goes low exactly when `casc_par_out` XOR `casc_par_in` (sampled at that edge) is 1.
- R10: At the first rising edge after `rst_n` returns high, the block loads its inputs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg | input | 2 | Topology: bit0 = narrow layout, bit1 = second device of a pair |
| sel_n | input | 2 | Active-low selects; both high freezes the data outputs |
| din | input | 25 | Command/address input word |
| par_in | input | 1 | Even-parity bit from the controller |
| casc_par_in | input | 1 | Partial parity from the first device of a pair |
| q_a | output | 25 | Registered outputs, first copy |
| q_b | output | 14 | Registered outputs, second copy (narrow layout) |
| casc_par_out | output | 1 | Registered partial parity |
| err_n | output | 1 | Parity error flag, active low |

## Verification
Data outputs and `casc_par_out` are due one rising edge after their inputs are sampled. `err_n` is due one edge later again, and in the second-device topology it also folds in the `casc_par_in` value present at that second edge. The bench changes inputs only at falling edges. After each rising edge it samples at the next falling edge and compares against a bench-side model that holds the partial parity from the previous step, so each flag is matched to the word that caused it. Directed tests check literal values for reset, release, control-bit exclusion, ignored upper bits and frozen outputs.

// File: rtl/cfg_regbuf_pkg.sv
package cfg_regbuf_pkg;

   typedef enum logic [1:0] {
      TOPO_WIDE   = 2'd0,
      TOPO_PAIR_1 = 2'd1,
      TOPO_PAIR_2 = 2'd2
   } topo_e;

   // bit0 selects the narrow fan-out layout, bit1 picks the pair position
   function automatic topo_e decode_topo(input logic [1:0] code);
      if (!code[0])     return TOPO_WIDE;
      else if (!code[1]) return TOPO_PAIR_1;
      else              return TOPO_PAIR_2;
   endfunction

endpackage

// File: rtl/cfg_regbuf_lanes.sv
module cfg_regbuf_lanes #(
   parameter int WIDE_W   = 25,
   parameter int NARROW_W = 14,
   parameter logic [WIDE_W-1:0] CTRL_MASK = {{(WIDE_W-2){1'b0}}, 2'b11}
) (
   input  logic                is_wide,
   input  logic [WIDE_W-1:0]   din,
   output logic [WIDE_W-1:0]   nxt_a,
   output logic [NARROW_W-1:0] nxt_b,
   output logic [WIDE_W-1:0]   chk
);

   for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
      logic used;
      if (i < NARROW_W) begin : g_low
         assign used     = din[i];
         assign nxt_b[i] = is_wide ? 1'b0 : din[i];
      end else begin : g_high
         assign used = is_wide ? din[i] : 1'b0;
      end
      assign nxt_a[i] = used;
      if (CTRL_MASK[i]) begin : g_ctrl
         assign chk[i] = 1'b0;
      end else begin : g_data
         assign chk[i] = used;
      end
   end

endmodule

// File: rtl/cfg_regbuf_hold_reg.sv
module cfg_regbuf_hold_reg #(
   parameter int W = 25,
   parameter logic [W-1:0] KEEP_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (KEEP_MASK[i]) begin : g_gated
         always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= 1'b0;
            else if (!hold) q[i] <= d[i];
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
         end
      end
   end

   // R4
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ((q & KEEP_MASK) == ($past(q) & KEEP_MASK)));

   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (q == '0));

endmodule

// File: rtl/cfg_regbuf_parity.sv
module cfg_regbuf_parity #(
   parameter int W = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] chk,
   input  logic         par_in,
   input  logic         casc_in,
   input  logic         is_first,
   input  logic         is_second,
   output logic         pp_q,
   output logic         err_n
);

   logic is_wide;
   logic pp_d;
   logic err_d;

   assign is_wide = !is_first && !is_second;
   assign pp_d    = (^chk) ^ (par_in & !is_second);
   assign err_d   = is_first ? 1'b1 : !(pp_q ^ (casc_in & is_second));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pp_q  <= 1'b0;
         err_n <= 1'b1;
      end else begin
         pp_q  <= pp_d;
         err_n <= err_d;
      end
   end

   // R8
   first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_first |=> err_n);

   // R6
   wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_wide ##1 is_wide |=> (err_n == !((^$past(chk, 2)) ^ $past(par_in, 2))));

   // R9
   second_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_second ##1 is_second |=> (err_n == !((^$past(chk, 2)) ^ $past(casc_in))));

endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
   import cfg_regbuf_pkg::*;
#(
   parameter int WIDE_W   = 25,
   parameter int NARROW_W = 14,
   parameter logic [WIDE_W-1:0] CTRL_MASK = {{(WIDE_W-2){1'b0}}, 2'b11}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg,
   input  logic [1:0]          sel_n,
   input  logic [WIDE_W-1:0]   din,
   input  logic                par_in,
   input  logic                casc_par_in,
   output logic [WIDE_W-1:0]   q_a,
   output logic [NARROW_W-1:0] q_b,
   output logic                casc_par_out,
   output logic                err_n
);

   localparam logic [WIDE_W-1:0]   KEEP_A = ~CTRL_MASK;
   localparam logic [NARROW_W-1:0] KEEP_B = ~CTRL_MASK[NARROW_W-1:0];

   if (NARROW_W < 1 || NARROW_W >= WIDE_W) begin : g_bad_widths
      $error("cfg_regbuf: NARROW_W must be in 1..WIDE_W-1");
   end

   topo_e topo;
   logic  is_wide, is_first, is_second, hold;
   logic [WIDE_W-1:0]   nxt_a, chk;
   logic [NARROW_W-1:0] nxt_b;

   assign topo      = decode_topo(cfg);
   assign is_wide   = (topo == TOPO_WIDE);
   assign is_first  = (topo == TOPO_PAIR_1);
   assign is_second = (topo == TOPO_PAIR_2);
   assign hold      = &sel_n;

   cfg_regbuf_lanes #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CTRL_MASK(CTRL_MASK)) i_lanes (
      .is_wide (is_wide),
      .din     (din),
      .nxt_a   (nxt_a),
      .nxt_b   (nxt_b),
      .chk     (chk)
   );

   cfg_regbuf_hold_reg #(.W(WIDE_W), .KEEP_MASK(KEEP_A)) i_reg_a (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .d     (nxt_a),
      .q     (q_a)
   );

   cfg_regbuf_hold_reg #(.W(NARROW_W), .KEEP_MASK(KEEP_B)) i_reg_b (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .d     (nxt_b),
      .q     (q_b)
   );

   cfg_regbuf_parity #(.W(WIDE_W)) i_parity (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk       (chk),
      .par_in    (par_in),
      .casc_in   (casc_par_in),
      .is_first  (is_first),
      .is_second (is_second),
      .pp_q      (casc_par_out),
      .err_n     (err_n)
   );

   // R3
   dup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_wide && !hold) |=> ((q_a[NARROW_W-1:0] == q_b) && (q_a[WIDE_W-1:NARROW_W] == '0)));

   // R2
   wide_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wide && !hold) |=> (q_b == '0));

endmodule

// File: tb/test_cfg_regbuf.sv
module test_cfg_regbuf;

   localparam int W = 25;
   localparam int N = 14;
   localparam logic [W-1:0] CTRL  = 25'h0000003;
   localparam logic [W-1:0] NMASK = 25'h0003FFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cfg = 2'b00;
   logic [1:0]   sel_n = 2'b00;
   logic [W-1:0] din = '0;
   logic         par_in = 1'b0;
   logic         casc_par_in = 1'b0;
   logic [W-1:0] q_a;
   logic [N-1:0] q_b;
   logic         casc_par_out;
   logic         err_n;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] m_qa = '0;
   logic [N-1:0] m_qb = '0;
   logic         m_pp = 1'b0;
   logic         m_err = 1'b1;

   always #10 clk = ~clk;

   cfg_regbuf i_cfg_regbuf (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .sel_n(sel_n), .din(din),
      .par_in(par_in), .casc_par_in(casc_par_in), .q_a(q_a), .q_b(q_b),
      .casc_par_out(casc_par_out), .err_n(err_n)
   );

   // {cfg, sel_n, din, par_in, casc_par_in}
   localparam logic [30:0] VEC [0:15] = '{
      {2'b00, 2'b10, 25'h1ABCDEF, 1'b0, 1'b0},
      {2'b00, 2'b01, 25'h0F0F0F0, 1'b1, 1'b0},
      {2'b00, 2'b00, 25'h1FFFFFF, 1'b1, 1'b1},
      {2'b00, 2'b11, 25'h0123456, 1'b0, 1'b0},
      {2'b00, 2'b11, 25'h0000004, 1'b1, 1'b0},
      {2'b10, 2'b10, 25'h0555555, 1'b0, 1'b1},
      {2'b10, 2'b00, 25'h0AAAAAA, 1'b1, 1'b0},
      {2'b01, 2'b10, 25'h1FC3A5C, 1'b0, 1'b0},
      {2'b01, 2'b01, 25'h0003FFF, 1'b1, 1'b1},
      {2'b01, 2'b11, 25'h1FFC000, 1'b1, 1'b0},
      {2'b01, 2'b10, 25'h000123C, 1'b0, 1'b1},
      {2'b11, 2'b01, 25'h0002468, 1'b1, 1'b0},
      {2'b11, 2'b10, 25'h1FF0F0F, 1'b0, 1'b1},
      {2'b11, 2'b11, 25'h0001111, 1'b0, 1'b0},
      {2'b11, 2'b00, 25'h0003330, 1'b1, 1'b1},
      {2'b11, 2'b10, 25'h1000000, 1'b0, 1'b1}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // bench model of one rising edge, from the requirements
   task automatic model_edge();
      logic wide, first, second, hold;
      logic [W-1:0] used, chk;
      wide   = !cfg[0];
      first  = cfg[0] && !cfg[1];
      second = cfg[0] && cfg[1];
      hold   = &sel_n;
      used   = wide ? din : (din & NMASK);
      chk    = used & ~CTRL;
      if (!rst_n) begin
         m_qa = '0; m_qb = '0; m_pp = 1'b0; m_err = 1'b1;
      end else begin
         m_qa  = hold ? ((m_qa & ~CTRL) | (used & CTRL)) : used;
         m_qb  = hold ? ((m_qb & ~CTRL[N-1:0]) | ((wide ? '0 : din[N-1:0]) & CTRL[N-1:0]))
                      : (wide ? '0 : din[N-1:0]);
         m_err = first ? 1'b1 : !(m_pp ^ (second & casc_par_in));
         m_pp  = (^chk) ^ (par_in & !second);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic compare_all();
      string dtag, ptag;
      if (&sel_n)       dtag = "R4";
      else if (!cfg[0]) dtag = "R2";
      else              dtag = "R3";
      if (&sel_n)      ptag = "R5";
      else if (!cfg[0]) ptag = "R6";
      else if (!cfg[1]) ptag = "R8";
      else             ptag = "R9";
      check(dtag, "q_a", 32'(q_a), 32'(m_qa));
      check(dtag, "q_b", 32'(q_b), 32'(m_qb));
      check(ptag, "casc_par_out", 32'(casc_par_out), 32'(m_pp));
      check(ptag, "err_n", 32'(err_n), 32'(m_err));
   endtask

   initial begin
      #4_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset with busy inputs
      din = 25'h1FFFFFF; par_in = 1'b1; casc_par_in = 1'b1; cfg = 2'b11;
      @(negedge clk);
      tick(); tick();
      check("R1", "q_a", 32'(q_a), 32'h0);
      check("R1", "q_b", 32'(q_b), 32'h0);
      check("R1", "casc_par_out", 32'(casc_par_out), 32'h0);
      check("R1", "err_n", 32'(err_n), 32'h1);

      // R10: first edge after release loads
      cfg = 2'b00; sel_n = 2'b00; din = 25'h0ABCDE0; par_in = 1'b0;
      rst_n = 1'b1;
      tick();
      check("R10", "q_a", 32'(q_a), 32'h0ABCDE0);
      compare_all();

      // vector table walk
      for (int k = 0; k < 16; k++) begin
         {cfg, sel_n, din, par_in, casc_par_in} = VEC[k];
         tick();
         compare_all();
      end

      // random walk over all topology codes, with good and bad parity
      for (int k = 0; k < 400; k++) begin
         cfg         = 2'($urandom);
         sel_n       = 2'($urandom);
         din         = 25'($urandom);
         par_in      = 1'($urandom);
         casc_par_in = 1'($urandom);
         tick();
         compare_all();
      end

      // R7: control bits stay out of parity (wide layout, selected)
      cfg = 2'b00; sel_n = 2'b00; din = 25'h0000010; par_in = 1'b1;
      tick();
      din = 25'h0000011;
      tick();
      check("R7", "err_n after even word", 32'(err_n), 32'h1);
      din = 25'h0000012;
      tick();
      check("R7", "err_n ctrl bit flip", 32'(err_n), 32'h1);
      tick();
      check("R7", "err_n ctrl bit flip 2", 32'(err_n), 32'h1);
      compare_all();

      // R3: upper inputs ignored in narrow layout (first device)
      cfg = 2'b01; din = 25'h1FFC00C; par_in = 1'b0;
      tick();
      check("R3", "q_a upper ignored", 32'(q_a), 32'h000000C);
      check("R3", "q_b copy", 32'(q_b), 32'h000C);
      check("R3", "casc_par_out upper ignored", 32'(casc_par_out), 32'h0);
      check("R8", "err_n first device", 32'(err_n), 32'h1);

      // R9: second device merges the partial from a first device
      cfg = 2'b11; din = 25'h0000010; par_in = 1'b1; casc_par_in = 1'b0;
      tick();
      check("R9", "casc_par_out ignores par_in", 32'(casc_par_out), 32'h1);
      casc_par_in = 1'b1; din = 25'h0;
      tick();
      check("R9", "err_n merged even", 32'(err_n), 32'h1);
      casc_par_in = 1'b1;
      tick();
      check("R9", "err_n merged odd", 32'(err_n), 32'h0);
      compare_all();

      // R4: frozen data bits, control bits still load
      cfg = 2'b00; sel_n = 2'b00; din = 25'h1234560; par_in = 1'b0; casc_par_in = 1'b0;
      tick();
      sel_n = 2'b11; din = 25'h0FEDCB3;
      tick();
      check("R4", "q_a frozen data, live ctrl", 32'(q_a), 32'h1234563);
      // R5: parity kept running while frozen
      check("R5", "casc_par_out while frozen", 32'(casc_par_out), 32'(^(25'h0FEDCB3 & ~CTRL)));
      compare_all();

      // R1: reset in mid-run
      rst_n = 1'b0;
      tick();
      check("R1", "q_a mid-run", 32'(q_a), 32'h0);
      check("R1", "err_n mid-run", 32'(err_n), 32'h1);
      compare_all();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule